// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block is the programmable feedback divider that follows an external two-modulus prescaler in a frequency synthesizer. Its clock is the prescaler output, so each clock edge stands for one prescaler output period. A divide cycle lasts B of those periods. During the first A of them the block asks the prescaler for the larger modulus P+1, and for the remaining B−A it asks for P. The loop therefore divides the RF input by P·B + A. At the end of each cycle the block emits a one-clock pulse to the phase detector.

B (13 bits), A (5 bits) and the prescaler pair select are sampled only when the counters reload, which happens at the end of each cycle. Values written mid-cycle therefore never disturb the cycle in progress. A settings check runs at every reload. It raises a flag when A exceeds B, when B is below the lower edge of the continuous range for the selected pair, or when the select code is reserved. When A exceeds B, the block counts with A reduced to B.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_n` is low, `mod_ctl`, `fb_pulse` and `cfg_bad` are 0. The first clock after release loads the settings without a pulse.
- R2: After a load with effective swallow count Aeff, `mod_ctl` is 1 for exactly the first Aeff clocks of the cycle and 0 for the rest (1 = request P+1).
- R3: `fb_pulse` is 1 for exactly one clock per cycle, on the last clock of a cycle that is Beff clocks long, where Beff = B, or 1 when B = 0.
- R4: Weighting each clock of a cycle by P+1 when `mod_ctl` is 1 and by P otherwise gives P·Beff + Aeff in total. P is 32, 16 or 8 for `p_sel` 00, 01 or 10.
- R5: If A > Beff at load, `cfg_bad` is 1 for that cycle and Aeff = Beff, so `mod_ctl` stays high for the whole cycle.
- R6: If Beff < P−1 at load, or `p_sel` = 11, `cfg_bad` is 1 for that cycle and counting still uses Beff. Code 11 is reserved and is counted as P = 8.
- R7: Values of `b_ratio`, `a_swallow` and `p_sel` applied mid-cycle have no effect until the next reload.
- R8: `cfg_bad` changes only at a reload and holds its value through the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_ratio | input | 13 | Main count B |
| a_swallow | input | 5 | Swallow count A |
| p_sel | input | 2 | Prescaler pair: 00 = 32/33, 01 = 16/17, 10 = 8/9, 11 = reserved |
| mod_ctl | output | 1 | Modulus request, 1 = P+1 |
| fb_pulse | output | 1 | One-clock end-of-cycle pulse to the phase detector |
| cfg_bad | output | 1 | Settings loaded for the current cycle were out of range |

## Verification
All three outputs come straight from registers loaded at a clock edge, so each result is due one edge after the state that causes it. Settings take effect one edge after the reload clock, which is the clock where `fb_pulse` is high. The bench drives inputs and samples outputs on the falling edge. A behavioural model advances on the rising edge, so every comparison sees the state from the edge just passed. Whole-cycle totals (length, swallow count, weighted ratio, flag stability) are checked on the pulse clock, when the cycle's last count is visible.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int BW = 13,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] b_ratio,
  input  logic [AW-1:0] a_swallow,
  input  logic [1:0]    p_sel,
  output logic          mod_ctl,
  output logic          fb_pulse,
  output logic          cfg_bad
);
  localparam logic [BW-1:0] ONE = BW'(1);

  logic          armed;
  logic [BW-1:0] mcnt;
  logic [AW-1:0] scnt;
  logic [BW-1:0] b_eff, a_wide, b_min;
  logic [AW-1:0] a_eff;
  logic          reload, a_over, bad_now;

  assign b_eff  = (b_ratio == '0) ? ONE : b_ratio;
  assign a_wide = BW'(a_swallow);
  assign a_over = a_wide > b_eff;
  assign a_eff  = a_over ? AW'(b_eff) : a_swallow;

  always_comb begin
    case (p_sel)
      2'b00:   b_min = BW'((1 << AW) - 1);
      2'b01:   b_min = BW'((1 << (AW - 1)) - 1);
      default: b_min = BW'((1 << (AW - 2)) - 1);
    endcase
  end

  assign bad_now = a_over || (b_eff < b_min) || (p_sel == 2'b11);
  assign reload  = !armed || (mcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      mcnt    <= '0;
      scnt    <= '0;
      cfg_bad <= 1'b0;
    end else if (reload) begin
      armed   <= 1'b1;
      mcnt    <= b_eff - ONE;
      scnt    <= a_eff;
      cfg_bad <= bad_now;
    end else begin
      mcnt <= mcnt - ONE;
      if (scnt != '0) scnt <= scnt - AW'(1);
    end
  end

  assign mod_ctl  = scnt != '0;
  assign fb_pulse = armed && (mcnt == '0);

  logic [BW:0] s_ext, m_ext;
  assign s_ext = (BW+1)'(scnt);
  assign m_ext = (BW+1)'(mcnt) + (BW+1)'(1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!mod_ctl && !fb_pulse));

  // R2
  swallow_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mod_ctl && !fb_pulse) |=> !mod_ctl);

  // R5
  swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (s_ext <= m_ext));

  // R3
  main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fb_pulse) |=> (mcnt == $past(mcnt) - ONE));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fb_pulse) |=> $stable(cfg_bad));
endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] b_ratio = 13'd40;
  logic [4:0]  a_swallow = 5'd5;
  logic [1:0]  p_sel = 2'b00;
  logic        mod_ctl, fb_pulse, cfg_bad;

  swallow_divider u_swallow_divider (
    .clk(clk), .rst_n(rst_n), .b_ratio(b_ratio), .a_swallow(a_swallow),
    .p_sel(p_sel), .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .cfg_bad(cfg_bad)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on the rising edge
  bit m_armed = 0, m_bad = 0;
  int m_len = 1, m_aef = 0, m_pos = 0, m_p = 32;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_bad = 0; m_pos = 0;
    end else if (!m_armed || m_pos == m_len - 1) begin
      int bmin;
      m_len = (b_ratio == 0) ? 1 : int'(b_ratio);
      m_aef = (int'(a_swallow) > m_len) ? m_len : int'(a_swallow);
      m_p   = (p_sel == 2'b00) ? 32 : (p_sel == 2'b01) ? 16 : 8;
      bmin  = m_p - 1;
      m_bad = (int'(a_swallow) > m_len) || (m_len < bmin) || (p_sel == 2'b11);
      m_pos = 0;
      m_armed = 1;
    end else begin
      m_pos++;
    end
  end

  int cyc_clk = 0, cyc_hi = 0;
  bit cyc_flag = 0;
  int pulses = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      check(!mod_ctl && !fb_pulse && !cfg_bad, "R1 reset outputs",
            {mod_ctl, fb_pulse, cfg_bad}, 0);
    end else begin
      bit e_fb, e_mod;
      e_fb  = m_armed && (m_pos == m_len - 1);
      e_mod = m_armed && (m_pos < m_aef);
      check(fb_pulse == e_fb, "R3 fb_pulse", fb_pulse, e_fb);
      check(mod_ctl == e_mod, "R2 mod_ctl", mod_ctl, e_mod);
      check(cfg_bad == m_bad, "R5,R6 cfg_bad", cfg_bad, m_bad);
      if (m_armed) begin
        cyc_clk++;
        if (mod_ctl) cyc_hi++;
        if (cyc_clk == 1) cyc_flag = cfg_bad;
        // R8
        check(cfg_bad == cyc_flag, "R8 flag stable in cycle", cfg_bad, cyc_flag);
        if (fb_pulse) begin
          pulses++;
          // R3 R7: length equals the value latched at this cycle's load
          check(cyc_clk == m_len, "R3,R7 cycle length", cyc_clk, m_len);
          check(cyc_hi == m_aef, "R2,R5 swallow clocks", cyc_hi, m_aef);
          // R4
          check(cyc_hi * (m_p + 1) + (cyc_clk - cyc_hi) * m_p == m_p * m_len + m_aef,
                "R4 total ratio", cyc_hi * (m_p + 1) + (cyc_clk - cyc_hi) * m_p,
                m_p * m_len + m_aef);
          cyc_clk = 0;
          cyc_hi = 0;
        end
      end
    end
  end

  task automatic set_cfg(input int b, input int a, input logic [1:0] p);
    b_ratio = 13'(b); a_swallow = 5'(a); p_sel = p;
  endtask

  task automatic wait_pulses(input int n);
    int start = pulses;
    while (pulses < start + n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first clock after release loads without a pulse
    check(!fb_pulse, "R1 no pulse on first load", fb_pulse, 0);
    wait_pulses(3);
    repeat (7) @(negedge clk);
    // R7: mid-cycle change, current cycle keeps B=40
    set_cfg(33, 31, 2'b00);
    wait_pulses(3);
    set_cfg(20, 3, 2'b01);  wait_pulses(3);
    set_cfg(9, 0, 2'b10);   wait_pulses(3);
    // R5: A above B
    set_cfg(10, 20, 2'b10); wait_pulses(2);
    check(cfg_bad, "R5 flag for A>B", cfg_bad, 1);
    // R6: B below continuous range, reserved select, B=0
    set_cfg(20, 2, 2'b00);  wait_pulses(2);
    check(cfg_bad, "R6 flag for small B", cfg_bad, 1);
    set_cfg(50, 4, 2'b11);  wait_pulses(2);
    set_cfg(1, 0, 2'b10);   wait_pulses(3);
    set_cfg(0, 5, 2'b10);   wait_pulses(3);
    set_cfg(8191, 31, 2'b00); wait_pulses(2);
    set_cfg(31, 31, 2'b00);   wait_pulses(2);
    check(!cfg_bad, "R6 flag clear at lower edge", cfg_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule